// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block models a byte-wide memory whose top eight addresses hold a calendar clock. The clock keeps seconds, minutes, hours, day of week, date, month, year and century as packed BCD. Every other address is plain storage. A single-cycle `tick` pulse, once per second, advances the time with full carry through to the century, so month lengths and leap years are handled.

A host reaches both the clock and the storage through an asynchronous-SRAM-style port. It has active-low chip select, read enable and write strobe, an address and separate byte-wide write and read data. `dq_oe` marks the cycles in which the block would drive a shared data bus. The interface is sampled on `clk`.

Five control bits live in the clock bytes:
- a stop bit that halts counting;
- a hold-for-write bit that sends host writes to shadow bytes and loads them into the counters when it is cleared;
- a hold-for-read bit that freezes the host's view of the time;
- a frequency-test bit;
- a supply flag.

The last two are plain stored bits in this model.

Top module: `rtc_bank`

## Requirements
- R1: Clock byte index is `addr[2:0]` when `addr[AW-1:3]` is all ones. The indices are 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. After reset they read 0x20, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01 and 0x00.
- R2: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `dq_oe` is 0, `rdata` is 0x00; this includes `oe_n` low together with `we_n` low.
- R3: A write is performed once per write cycle, on the first rising edge at which `ce_n` and `we_n` are both low. Holding them low longer does not repeat it.
- R4: Every address below the clock bytes stores and returns any byte written to it. Writing there leaves the clock unchanged.
- R5: With no other effect active, a tick adds one to seconds (bits 6:4 tens, 3:0 units). 59 wraps to 00 and adds one to minutes (bits 6:4, 3:0). Minutes 59 wraps to 00 and adds one to hours (bits 5:4, 3:0). Hours 23 wraps to 00.
- R6: When hours wrap, day of week (bits 2:0) advances, with 7 wrapping to 1.
- R7: When hours wrap, the date (bits 5:4, 3:0) advances. At the month's last day it returns to 01 and the month advances. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends at 29 when the year is a multiple of 4, otherwise at 28.
- R8: Month (bit 4 tens, 3:0 units) 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century (bits 5:4, 3:0), and century 39 wraps to 00.
- R9: While bit 7 of the seconds byte is 1, ticks are ignored.
- R10: Bit 7 of byte 0 is the write hold. Setting it copies all eight counter bytes into shadow bytes. While it is 1, counting continues and reads show the counters. Writes to bytes 1-7, and to the century field, go only to the shadow bytes. Writing byte 0 with bit 7 cleared loads the shadow bytes 1-7 into the counters and takes the century from that write.
- R11: Bit 6 of byte 0 is the read hold. When a write sets it, the counters are snapshotted. While it is 1, reads of bytes 1-7 return the snapshot. Reads of byte 0 return the live control bits over the snapshotted century.
- R12: A write that lands in the counters discards a tick in the same cycle. Such writes are a write to a clock byte while the write hold is 0, or the loading write of R10.
- R13: Bits outside the counting fields read back what was last written and survive counting. This covers bit 7 of minutes, bits 7:6 of hours and date, bits 7:5 of month, and bits 5:3 of day; bit 7 of day is the supply flag and bit 6 the frequency test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driving |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A host write and a one-second tick can land in the same cycle. The bench provokes this three ways: it writes the minutes byte while a tick is pulsed, it holds the write strobe low across several ticks, and it clears the write hold while a tick is pulsed. It judges each case by reading the seconds byte afterwards. The seconds must be unchanged when the write reached the counters, and must carry every later tick when the write hold only diverted the data to the shadow bytes. A behavioural model with integer calendar arithmetic is compared against `rdata` and `dq_oe` on every clock.

// File: rtl/rtc_bank.sv
module rtc_bank #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          dq_oe
);
  localparam int RAMN = (1 << AW) - 8;

  logic [7:0] mem_q [RAMN];
  logic [7:0] cnt_q [8];
  logic [7:0] stg_q [8];
  logic [7:0] snp_q [8];
  logic [7:0] nx    [8];
  logic       wr_q;

  function automatic logic [7:0] rst_val(input int k);
    case (k)
      0:       return 8'h20;
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] roll(input logic [7:0] v, input logic [7:0] m,
                                      input logic [7:0] lim, input logic [7:0] base);
    logic [7:0] f, n;
    f = v & m;
    if (f == lim)            n = base;
    else if (f[3:0] == 4'h9) n = {f[7:4] + 4'h1, 4'h0};
    else                     n = f + 8'h01;
    return (v & ~m) | (n & m);
  endfunction

  wire       is_clk = &addr[AW-1:3];
  wire [2:0] ci     = addr[2:0];
  wire       wflag  = cnt_q[0][7];
  wire       rflag  = cnt_q[0][6];
  wire       wr_sel = ~ce_n & ~we_n;
  wire       wr_go  = wr_sel & ~wr_q;
  wire       dir_wr = wr_go & is_clk & ~wflag;
  wire       stg_wr = wr_go & is_clk & wflag;
  wire       commit = stg_wr & (ci == 3'd0) & ~wdata[7];
  wire       snap   = wr_go & is_clk & (ci == 3'd0) & wdata[6] & ~rflag;
  wire       tick_ok = tick & ~cnt_q[1][7] & ~dir_wr & ~commit;

  wire       leap = cnt_q[7][4] ? (cnt_q[7][3:0] == 4'd2 || cnt_q[7][3:0] == 4'd6)
                                : (cnt_q[7][3:0] == 4'd0 || cnt_q[7][3:0] == 4'd4 ||
                                   cnt_q[7][3:0] == 4'd8);
  wire [4:0] mbin = cnt_q[6][4] ? 5'd10 + {1'b0, cnt_q[6][3:0]} : {1'b0, cnt_q[6][3:0]};
  logic [7:0] mlen;
  always_comb
    case (mbin)
      5'd2:                    mlen = leap ? 8'h29 : 8'h28;
      5'd4, 5'd6, 5'd9, 5'd11: mlen = 8'h30;
      default:                 mlen = 8'h31;
    endcase

  wire w1 = (cnt_q[1][6:0] == 7'h59);
  wire w2 = w1 && (cnt_q[2][6:0] == 7'h59);
  wire w3 = w2 && (cnt_q[3][5:0] == 6'h23);
  wire w5 = w3 && ((cnt_q[5] & 8'h3F) == mlen);
  wire w6 = w5 && (cnt_q[6][4:0] == 5'h12);
  wire w7 = w6 && (cnt_q[7] == 8'h99);

  always_comb begin
    nx[1] = roll(cnt_q[1], 8'h7F, 8'h59, 8'h00);
    nx[2] = w1 ? roll(cnt_q[2], 8'h7F, 8'h59, 8'h00) : cnt_q[2];
    nx[3] = w2 ? roll(cnt_q[3], 8'h3F, 8'h23, 8'h00) : cnt_q[3];
    nx[4] = w3 ? roll(cnt_q[4], 8'h07, 8'h07, 8'h01) : cnt_q[4];
    nx[5] = w3 ? roll(cnt_q[5], 8'h3F, mlen,  8'h01) : cnt_q[5];
    nx[6] = w5 ? roll(cnt_q[6], 8'h1F, 8'h12, 8'h01) : cnt_q[6];
    nx[7] = w6 ? roll(cnt_q[7], 8'hFF, 8'h99, 8'h00) : cnt_q[7];
    nx[0] = w7 ? roll(cnt_q[0], 8'h3F, 8'h39, 8'h00) : cnt_q[0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q <= 1'b0;
      for (int k = 0; k < 8; k++) begin
        cnt_q[k] <= rst_val(k);
        stg_q[k] <= rst_val(k);
        snp_q[k] <= rst_val(k);
      end
    end else begin
      wr_q <= wr_sel;
      if (tick_ok)
        for (int k = 0; k < 8; k++) cnt_q[k] <= nx[k];
      if (dir_wr) begin
        cnt_q[ci] <= wdata;
        if (ci == 3'd0 && wdata[7]) begin
          for (int k = 1; k < 8; k++) stg_q[k] <= cnt_q[k];
          stg_q[0] <= wdata;
        end
      end
      if (stg_wr) begin
        if (ci != 3'd0) stg_q[ci] <= wdata;
        else if (wdata[7]) begin
          cnt_q[0][7:6] <= wdata[7:6];
          stg_q[0]      <= wdata;
        end else begin
          for (int k = 1; k < 8; k++) cnt_q[k] <= stg_q[k];
          cnt_q[0] <= wdata;
        end
      end
      if (snap) begin
        for (int k = 1; k < 8; k++) snp_q[k] <= cnt_q[k];
        snp_q[0] <= dir_wr ? wdata : cnt_q[0];
      end
    end

  always_ff @(posedge clk)
    if (wr_go && !is_clk) mem_q[addr] <= wdata;

  logic [7:0] vbyte;
  always_comb
    if (rflag) vbyte = (ci == 3'd0) ? {cnt_q[0][7:6], snp_q[0][5:0]} : snp_q[ci];
    else       vbyte = cnt_q[ci];

  assign dq_oe = ~ce_n & ~oe_n & we_n;
  assign rdata = dq_oe ? (is_clk ? vbyte : mem_q[addr]) : 8'h00;
endmodule

// File: rtl/rtc_bank_chk.sv
module rtc_bank_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata,
  input logic          dq_oe,
  input logic          wr_go,
  input logic          tick_ok,
  input logic          wf,
  input logic          rf,
  input logic [7:0]    c1,
  input logic [7:0]    c2,
  input logic [5:0]    c3,
  input logic [2:0]    c4
);
  wire is_clk  = &addr[AW-1:3];
  wire rd_hold = dq_oe && is_clk && (addr[2:0] != 3'd0) && rf;

  // R2
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !we_n) |-> (!dq_oe && rdata == 8'h00));

  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && c1[6:0] == 7'h59) |=> (c1[6:0] == 7'h00 && !$stable(c2)));

  // R6
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && c1[6:0] == 7'h59 && c2[6:0] == 7'h59 && c3 == 6'h23 && c4 == 3'd7)
      |=> (c4 == 3'd1));

  // R9
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1[7] && !wr_go) |=> $stable(c1));

  // R11
  snap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_hold) && rd_hold && $stable(addr)) |-> $stable(rdata));

  // R12
  tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wr_go && is_clk && !wf && addr[2:0] != 3'd1) |=> $stable(c1));
endmodule

bind rtc_bank rtc_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .oe_n(oe_n), .we_n(we_n),
  .addr(addr), .rdata(rdata), .dq_oe(dq_oe), .wr_go(wr_go), .tick_ok(tick_ok),
  .wf(cnt_q[0][7]), .rf(cnt_q[0][6]), .c1(cnt_q[1]), .c2(cnt_q[2]),
  .c3(cnt_q[3][5:0]), .c4(cnt_q[4][2:0])
);

// File: tb/rtc_bank_test.sv
module rtc_bank_test;
  localparam int AW = 6;
  localparam int RAMN = (1 << AW) - 8;
  localparam time TCLK = 10;

  logic clk = 0, rst_n = 0, tick = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic dq_oe;
  int checks = 0, errors = 0;
  string cur = "R1";
  bit done = 0;

  rtc_bank #(.AW(AW)) uut (.*);

  always #(TCLK/2) clk = ~clk;

  logic [7:0] mc [8], ms [8], mp [8], mram [RAMN];
  bit mwq;

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] put(input logic [7:0] old, input logic [7:0] m, input int n);
    logic [7:0] b;
    b[7:4] = 4'(n / 10);
    b[3:0] = 4'(n % 10);
    return (old & ~m) | (b & m);
  endfunction
  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin : mdl
    logic [7:0] n [8];
    int s, mi, h, d, dt, mo, y, c, i;
    bit go, isc, wf, dir, com;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin
        mc[k] = (k == 0) ? 8'h20 : (k >= 4 && k <= 6) ? 8'h01 : 8'h00;
        ms[k] = mc[k];
        mp[k] = mc[k];
      end
      mwq = 0;
    end else begin
      go  = !ce_n && !we_n && !mwq;
      mwq = !ce_n && !we_n;
      isc = int'(addr) >= RAMN;
      i   = int'(addr) - RAMN;
      wf  = mc[0][7];
      dir = go && isc && !wf;
      com = go && isc && wf && i == 0 && !wdata[7];
      for (int k = 0; k < 8; k++) n[k] = mc[k];
      if (tick && !mc[1][7] && !dir && !com) begin
        s = b2i(mc[1] & 8'h7F); mi = b2i(mc[2] & 8'h7F); h = b2i(mc[3] & 8'h3F);
        d = int'(mc[4][2:0]); dt = b2i(mc[5] & 8'h3F); mo = b2i(mc[6] & 8'h1F);
        y = b2i(mc[7]); c = b2i(mc[0] & 8'h3F);
        s++;
        if (s > 59) begin
          s = 0; mi++;
          if (mi > 59) begin
            mi = 0; h++;
            if (h > 23) begin
              h = 0; d = (d == 7) ? 1 : d + 1;
              dt++;
              if (dt > mdays(mo, y)) begin
                dt = 1; mo++;
                if (mo > 12) begin
                  mo = 1; y++;
                  if (y > 99) begin
                    y = 0; c = (c == 39) ? 0 : c + 1;
                  end
                end
              end
            end
          end
        end
        n[1] = put(mc[1], 8'h7F, s); n[2] = put(mc[2], 8'h7F, mi);
        n[3] = put(mc[3], 8'h3F, h); n[4] = put(mc[4], 8'h07, d);
        n[5] = put(mc[5], 8'h3F, dt); n[6] = put(mc[6], 8'h1F, mo);
        n[7] = put(mc[7], 8'hFF, y); n[0] = put(mc[0], 8'h3F, c);
      end
      if (go && isc && i == 0 && wdata[6] && !mc[0][6]) begin
        for (int k = 1; k < 8; k++) mp[k] = mc[k];
        mp[0] = dir ? wdata : mc[0];
      end
      if (dir) begin
        n[i] = wdata;
        if (i == 0 && wdata[7]) begin
          for (int k = 1; k < 8; k++) ms[k] = mc[k];
          ms[0] = wdata;
        end
      end
      if (go && isc && wf) begin
        if (i != 0) ms[i] = wdata;
        else if (wdata[7]) begin
          n[0][7:6] = wdata[7:6];
          ms[0] = wdata;
        end else begin
          for (int k = 1; k < 8; k++) n[k] = ms[k];
          n[0] = wdata;
        end
      end
      if (go && !isc) mram[addr] = wdata;
      for (int k = 0; k < 8; k++) mc[k] = n[k];
    end
  end

  task automatic fail(input string what, input logic [7:0] act, input logic [7:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
  endtask

  task automatic step(input logic c, input logic o, input logic w, input int a,
                      input logic [7:0] d, input logic t);
    logic [7:0] ev;
    logic eo;
    int i;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = AW'(a); wdata = d; tick = t;
    #1;
    eo = !c && !o && w;
    i = a - RAMN;
    if (!eo) ev = 8'h00;
    else if (a < RAMN) ev = mram[a];
    else if (mc[0][6]) ev = (i == 0) ? {mc[0][7:6], mp[0][5:0]} : mp[i];
    else ev = mc[i];
    checks++;
    if (dq_oe !== eo || rdata !== ev) fail("model", rdata, ev);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    step(0, 1, 0, a, d, 0);
    step(1, 1, 1, 0, 8'h00, 0);
  endtask
  task automatic tk(input int n);
    repeat (n) step(1, 1, 1, 0, 8'h00, 1);
  endtask
  task automatic rd(input int a, input logic [7:0] exp);
    step(0, 0, 1, a, 8'h00, 0);
    checks++;
    if (rdata !== exp) fail($sformatf("read addr %0d", a), rdata, exp);
  endtask
  task automatic set_t(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(59, h); wr(58, m); wr(57, s);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset values
    cur = "R1";
    rd(63, 8'h00); rd(62, 8'h01); rd(61, 8'h01); rd(60, 8'h01);
    rd(59, 8'h00); rd(58, 8'h00); rd(57, 8'h00); rd(56, 8'h20);
    // R2 bus release
    cur = "R2";
    step(0, 0, 0, 0, 8'h5A, 0);
    checks++; if (dq_oe !== 1'b0) fail("dq_oe during write", {7'd0, dq_oe}, 8'h00);
    step(1, 0, 1, 0, 8'h00, 0);
    checks++; if (dq_oe !== 1'b0) fail("dq_oe unselected", {7'd0, dq_oe}, 8'h00);
    rd(0, 8'h5A);
    // R4 plain storage
    cur = "R4";
    wr(1, 8'hFF); wr(30, 8'hA5); wr(55, 8'h3C); wr(2, 8'h00);
    rd(1, 8'hFF); rd(30, 8'hA5); rd(55, 8'h3C); rd(2, 8'h00); rd(59, 8'h00);
    // R5 R6 R7 full-day carry into a new month, non-leap
    cur = "R5";
    wr(60, 8'h07); wr(61, 8'h28); wr(62, 8'h02); wr(63, 8'h23);
    set_t(8'h23, 8'h59, 8'h58);
    tk(1); rd(57, 8'h59);
    tk(1); rd(57, 8'h00); rd(58, 8'h00); rd(59, 8'h00);
    cur = "R6"; rd(60, 8'h01);
    cur = "R7"; rd(61, 8'h01); rd(62, 8'h03); rd(63, 8'h23);
    // R7 leap February
    wr(63, 8'h24); wr(62, 8'h02); wr(61, 8'h28);
    set_t(8'h23, 8'h59, 8'h59); tk(1);
    rd(61, 8'h29); rd(62, 8'h02);
    set_t(8'h23, 8'h59, 8'h59); tk(1);
    rd(61, 8'h01); rd(62, 8'h03);
    // R7 thirty-day month
    wr(62, 8'h04); wr(61, 8'h30);
    set_t(8'h23, 8'h59, 8'h59); tk(1);
    rd(61, 8'h01); rd(62, 8'h05);
    // R8 year and century wrap
    cur = "R8";
    wr(56, 8'h39); wr(63, 8'h99); wr(62, 8'h12); wr(61, 8'h31);
    set_t(8'h23, 8'h59, 8'h59); tk(1);
    rd(62, 8'h01); rd(61, 8'h01); rd(63, 8'h00); rd(56, 8'h00);
    wr(56, 8'h20);
    // R9 stopped oscillator
    cur = "R9";
    wr(57, 8'h90); tk(3); rd(57, 8'h90);
    wr(57, 8'h10); tk(1); rd(57, 8'h11);
    // R13 spare bits
    cur = "R13";
    wr(62, 8'hE1); rd(62, 8'hE1);
    set_t(8'hC5, 8'h59, 8'h59); tk(1);
    rd(59, 8'hC6); rd(62, 8'hE1); rd(58, 8'h00);
    // R3 held write strobe writes once
    cur = "R3";
    step(0, 1, 0, 57, 8'h10, 0);
    repeat (3) step(0, 1, 0, 57, 8'h10, 1);
    step(1, 1, 1, 0, 8'h00, 0);
    rd(57, 8'h13);
    // R12 tick with direct write is discarded
    cur = "R12";
    step(0, 1, 0, 58, 8'h30, 1);
    step(1, 1, 1, 0, 8'h00, 0);
    rd(57, 8'h13); rd(58, 8'h30);
    // R10 write hold and loading, commit coincides with tick
    cur = "R10";
    wr(56, 8'hA0); wr(57, 8'h45);
    rd(57, 8'h13); tk(2); rd(57, 8'h15); rd(56, 8'hA0);
    step(0, 1, 0, 56, 8'h20, 1);
    step(1, 1, 1, 0, 8'h00, 0);
    rd(57, 8'h45); rd(56, 8'h20); rd(58, 8'h30);
    // R11 read hold snapshot
    cur = "R11";
    wr(57, 8'h10); wr(56, 8'h60);
    tk(3); rd(57, 8'h10); rd(56, 8'h60);
    wr(56, 8'h20); rd(57, 8'h13);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired in %s", cur);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule